// File: doc/BRIEF.md
# Leaky Row Store with Read Restore and Refresh

This block models a small dynamic memory at the digital level. Each row is a word of charged or empty bit cells: a one is a charged cell, a zero an empty one. Charge leaks, so a row left alone for too long loses every one it held. Sensing a row empties its cells, so after each sense the block writes the same data back on its own. A refresh engine senses and rewrites the rows one at a time, in a fixed rotation and on a fixed schedule. A refresh that is due is served before any waiting user access.

Users reach the array through a request/ready port. A write is taken in one cycle. A read is taken in one cycle and returns its word in the next cycle, while the restore write runs. The port stays busy during that restore and during each refresh. A sticky decay flag tells the environment that a row ran past its retention time before it was rewritten, so a missed refresh can be seen.

Top module: `leaky_row_store`

## Requirements
- R1: After reset, reqReady is 1, rdValid is 0, decayFlag is 0, and every row reads back as zero.
- R2: A write is accepted on a clock edge where reqValid, reqWrite and reqReady are all 1. The row selected by reqAddr then holds reqWdata, and a later read returns that value.
- R3: A read is accepted on a clock edge where reqValid and reqReady are 1 and reqWrite is 0. In the following cycle rdValid is 1 and rdData holds the stored word. The sense leaves the row's cells empty.
- R4: The cycle after a read is accepted carries an automatic restore write of the sensed word to the same row. reqReady is 0 in that cycle, so a second read of the row returns the same word.
- R5: A refresh request is raised every REF_PERIOD cycles. It occupies two cycles, a sense and a restore, and reqReady is 0 in both. A pending refresh is served before a waiting user request. With no user traffic, reqReady is therefore 0 in exactly 2 of every REF_PERIOD cycles.
- R6: Refreshes visit rows in ascending address order and wrap from row ROWS-1 back to row 0.
- R7: A row that is neither written nor restored for RETAIN_LIMIT cycles has all its bits cleared to zero. A write restarts the row's retention time.
- R8: decayFlag goes to 1 when any row's retention time expires, and it stays 1 until reset.
- R9: When ROWS*REF_PERIOD is well below RETAIN_LIMIT, stored data survives idle periods of any length and decayFlag stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | User request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | AW | Row address |
| reqWdata | input | WIDTH | Write data |
| reqReady | output | 1 | Request is accepted on this edge if reqValid is 1 |
| rdValid | output | 1 | rdData holds the word of the read accepted in the previous cycle |
| rdData | output | WIDTH | Sensed read data |
| decayFlag | output | 1 | Sticky: a row's retention time expired |

## Verification
The bench builds two copies. The first uses 4 rows of 8 bits, a refresh every 5 cycles and a retention limit of 40. This sweeps every row with several data patterns and makes the busy pattern of reqReady exactly periodic, so it can be counted. It also shows that data survives long idle stretches because a full refresh rotation takes about 20 cycles. The second copy refreshes only every 100 cycles against a retention limit of 30. A row's decay, the retention restart after a rewrite, and the sticky flag can then be observed within a few dozen cycles.

// File: rtl/leaky_row_store_pkg.sv
package leaky_row_store_pkg;

  // Strobes from control to datapath for one cycle.
  typedef struct packed {
    logic sense;      // copy row into sense latch and empty the cells
    logic restore;    // drive sense latch back into the row
    logic userWrite;  // load user data into the row
  } cellOps_t;

  typedef enum logic [1:0] {
    ST_IDLE        = 2'd0,
    ST_USER_RESTORE = 2'd1,
    ST_REF_RESTORE = 2'd2
  } ctrlState_t;

endpackage

// File: rtl/leaky_row_store_datapath.sv
module leaky_row_store_datapath
  import leaky_row_store_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int WIDTH = 8,
  parameter int RETAIN_LIMIT = 40,
  localparam int AW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW = $clog2(RETAIN_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  cellOps_t         ops,
  input  logic [AW-1:0]    rowSel,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] senseData,
  output logic             decayFlag
);

  logic [WIDTH-1:0] cells [ROWS];
  logic [CW-1:0]    age   [ROWS];
  logic [ROWS-1:0]  expire;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic hit;
    logic recharge;
    assign hit      = (rowSel == AW'(r));
    assign recharge = hit && (ops.userWrite || ops.restore);
    assign expire[r] = !recharge && (age[r] == CW'(RETAIN_LIMIT - 1));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cells[r] <= '0;
        age[r]   <= '0;
      end else if (hit && ops.userWrite) begin
        cells[r] <= wrData;
        age[r]   <= '0;
      end else if (hit && ops.restore) begin
        cells[r] <= senseData;
        age[r]   <= '0;
      end else begin
        if (hit && ops.sense) cells[r] <= '0;
        if (age[r] != CW'(RETAIN_LIMIT)) begin
          age[r] <= age[r] + 1'b1;
          if (expire[r]) cells[r] <= '0;
        end
      end
    end
  end

  // Sense latch: holds the charge taken off the row until it is put back.
  always_ff @(posedge clk) begin
    if (!rstN) senseData <= '0;
    else if (ops.sense) senseData <= cells[rowSel];
  end

  always_ff @(posedge clk) begin
    if (!rstN) decayFlag <= 1'b0;
    else if (|expire) decayFlag <= 1'b1;
  end

  // R3: a sense leaves the row empty in the next cycle
  a_r3_sense_empties: assert property (@(posedge clk) disable iff (!rstN)
    (ops.sense && !ops.userWrite) |=> (cells[$past(rowSel)] == '0));

  // R8: the decay flag never drops without reset
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    decayFlag |=> decayFlag);

  // R7: a restored row carries the sensed word
  a_r7_restore_loads: assert property (@(posedge clk) disable iff (!rstN)
    (ops.restore && !ops.userWrite) |=> (cells[$past(rowSel)] == $past(senseData)));

endmodule

// File: rtl/leaky_row_store_ctrl.sv
module leaky_row_store_ctrl
  import leaky_row_store_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int REF_PERIOD = 5,
  localparam int AW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int TW = $clog2(REF_PERIOD + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic          reqWrite,
  input  logic [AW-1:0] reqAddr,
  output logic          reqReady,
  output logic          rdValid,
  output cellOps_t      ops,
  output logic [AW-1:0] rowSel
);

  ctrlState_t    state, stateNext;
  logic [TW-1:0] refTimer;
  logic          refPending;
  logic          timerWrap;
  logic [AW-1:0] refRow;
  logic [AW-1:0] heldRow;

  assign timerWrap = (refTimer == TW'(REF_PERIOD - 1));

  always_comb begin
    ops       = '0;
    rowSel    = heldRow;
    reqReady  = 1'b0;
    rdValid   = 1'b0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (refPending) begin
          ops.sense = 1'b1;
          rowSel    = refRow;
          stateNext = ST_REF_RESTORE;
        end else begin
          reqReady = 1'b1;
          rowSel   = reqAddr;
          if (reqValid) begin
            if (reqWrite) begin
              ops.userWrite = 1'b1;
            end else begin
              ops.sense = 1'b1;
              stateNext = ST_USER_RESTORE;
            end
          end
        end
      end
      ST_USER_RESTORE: begin
        ops.restore = 1'b1;
        rowSel      = heldRow;
        rdValid     = 1'b1;
        stateNext   = ST_IDLE;
      end
      ST_REF_RESTORE: begin
        ops.restore = 1'b1;
        rowSel      = refRow;
        stateNext   = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      refTimer   <= '0;
      refPending <= 1'b0;
      refRow     <= '0;
      heldRow    <= '0;
    end else begin
      state <= stateNext;
      if (timerWrap) refTimer <= '0;
      else refTimer <= refTimer + 1'b1;
      if (timerWrap) refPending <= 1'b1;
      else if (state == ST_REF_RESTORE) refPending <= 1'b0;
      if (state == ST_REF_RESTORE) begin
        if (refRow == AW'(ROWS - 1)) refRow <= '0;
        else refRow <= refRow + 1'b1;
      end
      if (state == ST_IDLE && !refPending && reqValid && !reqWrite)
        heldRow <= reqAddr;
    end
  end

  // R4: every sense is followed by a restore of the same row
  a_r4_restore_follows: assert property (@(posedge clk) disable iff (!rstN)
    ops.sense |=> (ops.restore && rowSel == $past(rowSel)));

  // R5: a pending refresh blocks user acceptance
  a_r5_refresh_first: assert property (@(posedge clk) disable iff (!rstN)
    (refPending && state == ST_IDLE) |-> (!reqReady && ops.sense && !ops.userWrite));

  // R6: refresh rotation advances by one and wraps
  a_r6_row_order: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REF_RESTORE) |=>
      (refRow == (($past(refRow) == AW'(ROWS - 1)) ? '0 : $past(refRow) + 1'b1)));

  // R4: busy while restoring
  a_r4_busy_restore: assert property (@(posedge clk) disable iff (!rstN)
    ops.restore |-> !reqReady);

  // R2: at most one strobe per cycle
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ops.sense, ops.restore, ops.userWrite}));

endmodule

// File: rtl/leaky_row_store.sv
module leaky_row_store
  import leaky_row_store_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int WIDTH = 8,
  parameter int REF_PERIOD = 5,
  parameter int RETAIN_LIMIT = 40,
  localparam int AW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [AW-1:0]    reqAddr,
  input  logic [WIDTH-1:0] reqWdata,
  output logic             reqReady,
  output logic             rdValid,
  output logic [WIDTH-1:0] rdData,
  output logic             decayFlag
);

  cellOps_t      ops;
  logic [AW-1:0] rowSel;

  leaky_row_store_ctrl #(
    .ROWS(ROWS),
    .REF_PERIOD(REF_PERIOD)
  ) ctrl_i (
    .clk(clk),
    .rstN(rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqAddr(reqAddr),
    .reqReady(reqReady),
    .rdValid(rdValid),
    .ops(ops),
    .rowSel(rowSel)
  );

  leaky_row_store_datapath #(
    .ROWS(ROWS),
    .WIDTH(WIDTH),
    .RETAIN_LIMIT(RETAIN_LIMIT)
  ) dp_i (
    .clk(clk),
    .rstN(rstN),
    .ops(ops),
    .rowSel(rowSel),
    .wrData(reqWdata),
    .senseData(rdData),
    .decayFlag(decayFlag)
  );

endmodule

// File: tb/leaky_row_store_tb_top.sv
`timescale 1ns/1ps
module leaky_row_store_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic       reqValid [2];
  logic       reqWrite [2];
  logic [1:0] reqAddr  [2];
  logic [7:0] reqWdata [2];
  logic       reqReady [2];
  logic       rdValid  [2];
  logic [7:0] rdData   [2];
  logic       decayFlag[2];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  leaky_row_store #(.ROWS(4), .WIDTH(8), .REF_PERIOD(5), .RETAIN_LIMIT(40)) dut_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid[0]), .reqWrite(reqWrite[0]), .reqAddr(reqAddr[0]),
    .reqWdata(reqWdata[0]), .reqReady(reqReady[0]), .rdValid(rdValid[0]),
    .rdData(rdData[0]), .decayFlag(decayFlag[0]));

  leaky_row_store #(.ROWS(4), .WIDTH(8), .REF_PERIOD(100), .RETAIN_LIMIT(30)) dut_slow_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid[1]), .reqWrite(reqWrite[1]), .reqAddr(reqAddr[1]),
    .reqWdata(reqWdata[1]), .reqReady(reqReady[1]), .rdValid(rdValid[1]),
    .rdData(rdData[1]), .decayFlag(decayFlag[1]));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input int u, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reqValid[u] = 1'b1; reqWrite[u] = 1'b1; reqAddr[u] = a; reqWdata[u] = d;
    while (!reqReady[u]) @(negedge clk);
    @(negedge clk);
    reqValid[u] = 1'b0; reqWrite[u] = 1'b0;
  endtask

  task automatic doRead(input int u, input logic [1:0] a,
                        output logic [7:0] d, output logic v, output logic rdy);
    @(negedge clk);
    reqValid[u] = 1'b1; reqWrite[u] = 1'b0; reqAddr[u] = a;
    while (!reqReady[u]) @(negedge clk);
    @(negedge clk);
    reqValid[u] = 1'b0;
    d = rdData[u]; v = rdValid[u]; rdy = reqReady[u];
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic v, rdy;
    logic [7:0] model [4];
    int lowCount;
    for (int u = 0; u < 2; u++) begin
      reqValid[u] = 0; reqWrite[u] = 0; reqAddr[u] = 0; reqWdata[u] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state on both copies
    check("R1 ready", {31'd0, reqReady[0]}, 1);
    check("R1 rdValid", {31'd0, rdValid[0]}, 0);
    check("R1 decay", {31'd0, decayFlag[0]}, 0);
    check("R1 decay slow", {31'd0, decayFlag[1]}, 0);

    // R7/R8 on the slow-refresh copy: row0 decays, row1 rewritten in time
    doWrite(1, 2'd0, 8'hFF);
    doWrite(1, 2'd1, 8'h3C);
    idle(20);
    doWrite(1, 2'd1, 8'h3C);
    idle(20);
    doRead(1, 2'd1, d, v, rdy);
    check("R7 rewritten row kept", {24'd0, d}, 32'h3C);
    doRead(1, 2'd0, d, v, rdy);
    check("R7 expired row cleared", {24'd0, d}, 0);
    check("R8 flag set", {31'd0, decayFlag[1]}, 1);
    idle(200);
    check("R8 flag sticky", {31'd0, decayFlag[1]}, 1);

    // R1: all rows of the main copy read zero
    for (int r = 0; r < 4; r++) begin
      doRead(0, r[1:0], d, v, rdy);
      check("R1 row zero", {24'd0, d}, 0);
    end

    // R2/R3/R4: sweep patterns over all rows
    for (int p = 0; p < 4; p++) begin
      for (int r = 0; r < 4; r++) begin
        case (p)
          0: model[r] = 8'hFF;
          1: model[r] = 8'hA5 ^ 8'(r);
          2: model[r] = 8'(r * 37 + 1);
          default: model[r] = 8'h00;
        endcase
        doWrite(0, r[1:0], model[r]);
      end
      for (int r = 0; r < 4; r++) begin
        doRead(0, r[1:0], d, v, rdy);
        check("R2 R3 read data", {24'd0, d}, {24'd0, model[r]});
        check("R3 rdValid", {31'd0, v}, 1);
        check("R4 busy during restore", {31'd0, rdy}, 0);
        doRead(0, r[1:0], d, v, rdy);
        check("R4 reread after restore", {24'd0, d}, {24'd0, model[r]});
      end
    end

    // R5: idle busy pattern of reqReady is 2 of every 5 cycles
    idle(10);
    lowCount = 0;
    for (int c = 0; c < 50; c++) begin
      @(negedge clk);
      if (!reqReady[0]) lowCount++;
    end
    check("R5 refresh busy count", lowCount, 20);

    // R6/R9: long idle, data survives through refresh rotation
    for (int r = 0; r < 4; r++) begin
      model[r] = 8'h81 | 8'(r << 3);
      doWrite(0, r[1:0], model[r]);
    end
    idle(400);
    for (int r = 0; r < 4; r++) begin
      doRead(0, r[1:0], d, v, rdy);
      check("R6 R9 data held", {24'd0, d}, {24'd0, model[r]});
    end
    check("R9 no decay", {31'd0, decayFlag[0]}, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule